// File: doc/BRIEF.md
# Split-Section Montgomery Modular Multiplier

This block multiplies two operands modulo an odd modulus in the Montgomery domain. It returns x·y·2^-w mod m, where w is the active operand width. The nominal datapath is a chain of T stages, each covering N/T bits. The chain can be cut into a low section of TL stages and a high section made of the remaining stages. A two-bit select, sampled at start, picks whether a multiplication uses the whole chain or one section alone. Each choice has its own operand width and its own fixed latency.

The multiplier and the modulus are loaded into holding registers with their own strobes. The multiplicand is sampled on the start strobe. The result register keeps its value until the next multiplication completes. A one-cycle ready pulse marks the cycle in which the new value first appears.

Top module: `montmul_split`

## Requirements
- R1: The select sampled with start sets the operand width w: 2'b11 gives N bits, 2'b10 gives N-(N/T)*TL bits, and 2'b01 gives (N/T)*TL bits.
- R2: For odd m and x, y below m (all taken over w bits), the result equals x·y·2^-w mod m and lies in [0, m).
- R3: ready rises exactly T+2*(w-1) clock edges after the edge that accepts start, and it stays high for a single cycle.
- R4: Bits of x, y and m at position w and above have no effect, and result bits at position w and above are zero.
- R5: A start with select 2'b00, or with any select other than 2'b11 when SPLIT is 0, is ignored: no ready pulse follows and result keeps its value.
- R6: A start that arrives while a multiplication is in progress is ignored. The running operation finishes on its own schedule with its own operands.
- R7: result changes only on the edge that raises ready, and it holds its value in every other cycle.
- R8: load_x and load_m may rewrite the holding registers during a multiplication without changing that multiplication's result.
- R9: While reset is asserted, ready and result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | N | Multiplier operand, captured by load_x |
| y_in | input | N | Multiplicand operand, captured by start |
| m_in | input | N | Odd modulus, captured by load_m |
| load_x | input | 1 | Capture x_in into the holding register |
| load_m | input | 1 | Capture m_in into the holding register |
| start | input | 1 | Begin a multiplication with the current select |
| sel | input | 2 | Section select: 11 full, 10 high, 01 low |
| ready | output | 1 | One-cycle completion pulse |
| result | output | N | Montgomery product, held until the next completion |

## Verification
The low section, 4 bits wide in the bench configuration, is swept over every odd modulus and every operand pair below it. This sweep exposes errors in the per-bit reduction and in the final subtraction, including the corner where the accumulator lands exactly on m. The 12-bit high section and the 16-bit full chain run with patterns at the edges (0, 1, m-1, modulus 1, all-ones modulus) and with pseudo-random operands. Random junk is placed above w in every operand, so a masking error or a wrong width shows up as a wrong product. The latency is counted for every multiplication. Separate runs test the illegal select, a start while busy, reloading the holding registers during a run, and a second instance built with the split disabled.

// File: rtl/montmul_split.sv
module montmul_split #(
  parameter int N     = 1536,
  parameter int T     = 96,
  parameter int TL    = 32,
  parameter bit SPLIT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] m_in,
  input  logic         load_x,
  input  logic         load_m,
  input  logic         start,
  input  logic [1:0]   sel,
  output logic         ready,
  output logic [N-1:0] result
);
  localparam int WL = (N / T) * TL;
  localparam int WH = N - WL;
  localparam int AW = N + 2;
  localparam int CW = $clog2(T + 2 * N + 1);

  logic [N-1:0]  xr, mr, xs, ys, mw;
  logic [AW-1:0] acc;
  logic [CW-1:0] cnt, last, wcur, w_sel;
  logic          busy, sel_ok;
  logic [N-1:0]  mask;
  logic [AW-1:0] sum1, sum2, step, reduced;

  assign sel_ok = (sel == 2'b11) || (SPLIT && (sel == 2'b01 || sel == 2'b10));

  always_comb begin
    case (sel)
      2'b10:   w_sel = CW'(WH);
      2'b01:   w_sel = CW'(WL);
      default: w_sel = CW'(N);
    endcase
  end

  assign mask    = {N{1'b1}} >> (CW'(N) - w_sel);
  assign sum1    = acc + (xs[0] ? {2'b00, ys} : '0);
  assign sum2    = sum1 + (sum1[0] ? {2'b00, mw} : '0);
  assign step    = sum2 >> 1;
  assign reduced = (acc >= {2'b00, mw}) ? acc - {2'b00, mw} : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      xr <= '0; mr <= '0; xs <= '0; ys <= '0; mw <= '0;
      acc <= '0; cnt <= '0; last <= '0; wcur <= '0;
      busy <= 1'b0; ready <= 1'b0; result <= '0;
    end else begin
      ready <= 1'b0;
      if (load_x) xr <= x_in;
      if (load_m) mr <= m_in;
      if (!busy) begin
        if (start && sel_ok) begin
          busy <= 1'b1;
          cnt  <= '0;
          wcur <= w_sel;
          last <= CW'(T) + (w_sel << 1) - CW'(3);
          xs   <= xr & mask;
          ys   <= y_in & mask;
          mw   <= mr & mask;
          acc  <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt < wcur) begin
          acc <= step;
          xs  <= xs >> 1;
        end else if (cnt == wcur) begin
          acc <= reduced;
        end
        if (cnt == last) begin
          busy   <= 1'b0;
          ready  <= 1'b1;
          result <= acc[N-1:0];
        end
      end
    end
  end
endmodule

module montmul_split_chk #(
  parameter int N = 1536
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   sel,
  input logic         busy,
  input logic         ready,
  input logic [N-1:0] result,
  input logic [N-1:0] mw
);
  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  assert_result_bound_R2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (result < mw));
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ready |-> $stable(result));
  assert_illegal_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && sel == 2'b00) |=> !busy);
  assert_ready_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(busy));
endmodule

bind montmul_split montmul_split_chk #(.N(N)) chk (
  .clk(clk), .rst(rst), .start(start), .sel(sel), .busy(busy),
  .ready(ready), .result(result), .mw(mw)
);

// File: tb/montmul_split_test.sv
module montmul_split_test;
  localparam int N = 16, T = 4, TL = 1;
  localparam int WL = (N / T) * TL, WH = N - WL;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
  logic load_x = 0, load_m = 0, start = 0, start2 = 0;
  logic [1:0] sel = 2'b11;
  logic ready, ready2;
  logic [N-1:0] result, result2;
  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  montmul_split #(.N(N), .T(T), .TL(TL), .SPLIT(1'b1)) uut (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .m_in(m_in),
    .load_x(load_x), .load_m(load_m), .start(start), .sel(sel),
    .ready(ready), .result(result));

  montmul_split #(.N(N), .T(T), .TL(TL), .SPLIT(1'b0)) uut_nosplit (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .m_in(m_in),
    .load_x(load_x), .load_m(load_m), .start(start2), .sel(sel),
    .ready(ready2), .result(result2));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  function automatic logic [15:0] rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf;
  endfunction

  function automatic longint mref(longint x, longint y, longint m, int w);
    longint rinv = 0;
    if (m == 1) return 0;
    for (longint k = 1; k < m; k++)
      if (((k << w) % m) == 1) begin rinv = k; break; end
    return (((x * y) % m) * rinv) % m;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(bit second, logic [1:0] s, longint x, longint y, longint m, int w);
    longint junk = (w < N) ? (longint'(rnd()) << w) : 0;
    @(negedge clk);
    x_in = N'(x | junk); y_in = N'(y | (junk ^ (longint'(rnd()) << w)));
    m_in = N'(m | junk); load_x = 1; load_m = 1;
    @(negedge clk);
    load_x = 0; load_m = 0; sel = s;
    if (second) start2 = 1; else start = 1;
    @(negedge clk);
    start = 0; start2 = 0;
  endtask

  task automatic await_ready(bit second, int k0, output int k);
    k = k0;
    while (k < 200) begin
      @(posedge clk); @(negedge clk);
      k++;
      if ((second ? ready2 : ready) === 1'b1) break;
    end
  endtask

  task automatic mult(logic [1:0] s, longint x, longint y, longint m, int w);
    int k;
    launch(0, s, x, y, m, w);
    await_ready(0, 0, k);
    chk("R3 latency", k, T + 2 * (w - 1));
    chk("R2/R4 product", result, mref(x, y, m, w));
    @(negedge clk);
    chk("R3 pulse width", ready, 0);
  endtask

  initial begin
    int k;
    longint prev, ms;
    repeat (3) @(negedge clk);
    chk("R9 ready in reset", ready, 0);
    chk("R9 result in reset", result, 0);
    rst = 0;

    // R1 low section exhaustive sweep
    for (int m = 1; m < 16; m += 2)
      for (int x = 0; x < m; x++)
        for (int y = 0; y < m; y++)
          mult(2'b01, x, y, m, WL);

    // R1 high section and full chain patterns
    for (int sw = 0; sw < 2; sw++) begin
      int w = sw ? N : WH;
      logic [1:0] s = sw ? 2'b11 : 2'b10;
      longint top = (longint'(1) << w) - 1;
      for (int i = 0; i < 8; i++) begin
        ms = (i == 0) ? top : (i == 1) ? 1 : (i == 2) ? 3 :
             (i == 3) ? ((top >> 1) + 2) : ((longint'(rnd()) & top) | 1);
        mult(s, 0, ms - 1, ms, w);
        mult(s, 1, 1, ms, w);
        mult(s, ms - 1, ms - 1, ms, w);
        for (int j = 0; j < 6; j++)
          mult(s, longint'(rnd()) % ms, longint'(rnd()) % ms, ms, w);
      end
    end

    // R8 reload holding registers mid-run
    launch(0, 2'b11, 16'h1234, 16'h0F0F, 16'hFFF1, N);
    x_in = 16'h7777; m_in = 16'h0003; load_x = 1; load_m = 1;
    @(negedge clk);
    load_x = 0; load_m = 0;
    await_ready(0, 1, k);
    chk("R8 latency", k, T + 2 * (N - 1));
    chk("R8 result unaffected", result, mref(16'h1234, 16'h0F0F, 16'hFFF1, N));

    // R6 start while busy
    launch(0, 2'b11, 16'h0ABC, 16'h1357, 16'hE001, N);
    @(negedge clk);
    sel = 2'b01; y_in = 16'h0005; start = 1;
    @(negedge clk);
    start = 0;
    await_ready(0, 2, k);
    chk("R6 latency kept", k, T + 2 * (N - 1));
    chk("R6 result kept", result, mref(16'h0ABC, 16'h1357, 16'hE001, N));

    // R5 illegal select
    prev = result;
    launch(0, 2'b00, 3, 5, 11, N);
    k = 0;
    repeat (2 * N + T + 4) begin
      @(negedge clk);
      if (ready) k++;
    end
    chk("R5 no ready on sel 00", k, 0);
    chk("R5 result held", result, prev);

    // R5 split disabled: only full selection accepted
    for (int sw = 0; sw < 2; sw++) begin
      prev = result2;
      launch(1, sw ? 2'b10 : 2'b01, 3, 5, 11, sw ? WH : WL);
      k = 0;
      repeat (2 * N + T + 4) begin
        @(negedge clk);
        if (ready2) k++;
      end
      chk("R5 nosplit section ignored", k, 0);
      chk("R5 nosplit result held", result2, prev);
    end
    launch(1, 2'b11, 16'h2222, 16'h0101, 16'hC003, N);
    await_ready(1, 0, k);
    chk("R5 nosplit full latency", k, T + 2 * (N - 1));
    chk("R5 nosplit full product", result2, mref(16'h2222, 16'h0101, 16'hC003, N));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule